// File: doc/BRIEF.md
# Atomic Read-Modify-Write Result Unit

This unit computes the new memory word for an atomic memory operation. Each request carries three things: the word currently held in memory, an operand word from the requester, and a 4-bit operation selector. The supported operations are wrapping addition, the three bitwise logic functions, signed and unsigned maximum and minimum, and exchange. The unit is registered. When the valid strobe is high it captures a request, and one clock later it presents the computed word, the unchanged original word (the value an atomic read returns) and a result-valid strobe.

A memory controller places the unit between its read port and its write port. The computed word is written back to memory. The original word goes to the requester as read data.

Top module: `amo_unit`

## Requirements
- R1: Selector 0 produces (original + operand) mod 2^W. The carry out is dropped.
- R2: Selectors 1, 2 and 3 produce the bitwise AND, OR and XOR, in that order, of original and operand.
- R3: Selector 4 produces the larger and selector 5 the smaller of the two words, both read as two's complement with bit W-1 as the sign.
- R4: Selector 6 produces the larger and selector 7 the smaller of the two words, both read as unsigned.
- R5: Selector 8 produces the operand word. Every selector value from 9 to 15 also produces the operand word.
- R6: The returned read data equals the original word captured with the same request, with no change.
- R7: Result valid is high in the cycle after a clock edge that saw request valid high, and low otherwise. Result and read data change only when a request is accepted.
- R8: While the active-low reset is asserted, result valid, result and read data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Request strobe |
| reqOp | input | 4 | Operation selector |
| reqOrig | input | W | Word read from memory |
| reqOperand | input | W | Requester operand |
| rspValid | output | 1 | Result strobe, one cycle after the request |
| rspResult | output | W | Word to write back |
| rspOrig | output | W | Original word returned as read data |

## Verification
A fault in the compare path, for example a sign bit handled wrongly, shows up at rspResult on the first request whose operands have different signs. It is visible exactly one clock after that request. Corner words (zero, all ones, the most negative value and the most positive value) are paired against each other for every selector from 0 to 15, so that such faults appear within the directed sweep. A faulty valid register or capture enable shows up as a valid pulse that is missing or extra, or as outputs that move during idle cycles, on the next edge.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int OP_W = 4;
  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0, OP_AND = 4'd1, OP_OR = 4'd2, OP_XOR = 4'd3,
    OP_SMAX = 4'd4, OP_SMIN = 4'd5, OP_UMAX = 4'd6, OP_UMIN = 4'd7,
    OP_SWAP = 4'd8
  } amoOp_e;

  typedef struct packed {
    logic capture;
    logic isSigned;
    logic pickMax;
    logic [2:0] fnSel;
  } amoCtl_t;

  localparam logic [2:0] FN_ADD = 3'd0;
  localparam logic [2:0] FN_AND = 3'd1;
  localparam logic [2:0] FN_OR  = 3'd2;
  localparam logic [2:0] FN_XOR = 3'd3;
  localparam logic [2:0] FN_MM  = 3'd4;
  localparam logic [2:0] FN_SWP = 3'd5;
endpackage

// File: rtl/amo_ctrl.sv
module amo_ctrl
  import amo_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [OP_W-1:0] reqOp,
  output amoCtl_t         ctl,
  output logic            rspValid
);
  always_comb begin
    ctl = '0;
    ctl.capture = reqValid;
    ctl.fnSel = FN_SWP;
    case (reqOp)
      OP_ADD:  ctl.fnSel = FN_ADD;
      OP_AND:  ctl.fnSel = FN_AND;
      OP_OR:   ctl.fnSel = FN_OR;
      OP_XOR:  ctl.fnSel = FN_XOR;
      OP_SMAX: begin ctl.fnSel = FN_MM; ctl.isSigned = 1'b1; ctl.pickMax = 1'b1; end
      OP_SMIN: begin ctl.fnSel = FN_MM; ctl.isSigned = 1'b1; end
      OP_UMAX: begin ctl.fnSel = FN_MM; ctl.pickMax = 1'b1; end
      OP_UMIN: ctl.fnSel = FN_MM;
      default: ctl.fnSel = FN_SWP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
endmodule

// File: rtl/amo_dpath.sv
module amo_dpath
  import amo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  amoCtl_t      ctl,
  input  logic [W-1:0] orig,
  input  logic [W-1:0] operand,
  output logic [W-1:0] result,
  output logic [W-1:0] origOut
);
  localparam int MSB = W - 1;
  logic [W-1:0] sum, mmVal, nextVal;
  logic         origGreater;

  assign sum = orig + operand;

  // Flipping the sign bits turns a signed compare into an unsigned one
  logic [W-1:0] aCmp, bCmp;
  always_comb begin
    aCmp = orig;
    bCmp = operand;
    aCmp[MSB] = orig[MSB] ^ ctl.isSigned;
    bCmp[MSB] = operand[MSB] ^ ctl.isSigned;
  end
  assign origGreater = aCmp > bCmp;
  assign mmVal = (origGreater == ctl.pickMax) ? orig : operand;

  always_comb begin
    case (ctl.fnSel)
      FN_ADD:  nextVal = sum;
      FN_AND:  nextVal = orig & operand;
      FN_OR:   nextVal = orig | operand;
      FN_XOR:  nextVal = orig ^ operand;
      FN_MM:   nextVal = mmVal;
      default: nextVal = operand;
    endcase
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      result  <= '0;
      origOut <= '0;
    end else if (ctl.capture) begin
      result  <= nextVal;
      origOut <= orig;
    end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [OP_W-1:0] reqOp,
  input  logic [W-1:0]    reqOrig,
  input  logic [W-1:0]    reqOperand,
  output logic            rspValid,
  output logic [W-1:0]    rspResult,
  output logic [W-1:0]    rspOrig
);
  amoCtl_t ctl;

  amo_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .ctl(ctl), .rspValid(rspValid)
  );

  amo_dpath #(.W(W)) uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .orig(reqOrig), .operand(reqOperand),
    .result(rspResult), .origOut(rspOrig)
  );
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         reqValid,
  input logic [3:0]   reqOp,
  input logic [W-1:0] reqOrig,
  input logic [W-1:0] reqOperand,
  input logic         rspValid,
  input logic [W-1:0] rspResult,
  input logic [W-1:0] rspOrig
);
  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(rspResult) && $stable(rspOrig)));
  assert_orig_passthru_R6: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspOrig == $past(reqOrig));
  assert_swap_fallback_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp >= 4'd8) |=> rspResult == $past(reqOperand));
  assert_add_wraps_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 4'd0) |=> rspResult == W'($past(reqOrig) + $past(reqOperand)));
  always @(posedge clk)
    if (!rstN) assert_reset_clear_R8: assert (!rspValid && rspResult == '0 && rspOrig == '0);
endmodule

bind amo_unit amo_unit_chk #(.W(W)) uChk (.*);

// File: tb/sim_amo_unit.sv
`timescale 1ns/1ps
module sim_amo_unit;
  localparam int W = 32;
  logic clk = 1'b0, rstN = 1'b0, reqValid = 1'b0;
  logic [3:0] reqOp = '0;
  logic [W-1:0] reqOrig = '0, reqOperand = '0;
  logic rspValid;
  logic [W-1:0] rspResult, rspOrig;
  int nChecks = 0, nFails = 0;
  logic [2*W+4-1:0] expQ[$];  // {reqTag(4 bits op), result, orig}
  bit done = 0;

  always #2 clk = ~clk;

  amo_unit #(.W(W)) u0 (.*);

  function automatic logic [W-1:0] model(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    case (op)
      4'd0: return a + b;
      4'd1: return a & b;
      4'd2: return a | b;
      4'd3: return a ^ b;
      4'd4: return ($signed(a) > $signed(b)) ? a : b;
      4'd5: return ($signed(a) < $signed(b)) ? a : b;
      4'd6: return (a > b) ? a : b;
      4'd7: return (a < b) ? a : b;
      default: return b;
    endcase
  endfunction

  function automatic string reqName(input logic [3:0] op);
    if (op == 0) return "R1";
    if (op <= 3) return "R2";
    if (op <= 5) return "R3";
    if (op <= 7) return "R4";
    return "R5";
  endfunction

  task automatic check(input string r, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqOrig = a; reqOperand = b;
    expQ.push_back({op, model(op, a, b), a});
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0; reqOp = 4'hF; reqOrig = $urandom; reqOperand = $urandom;
  endtask

  // monitor: samples at negedge, which is after the edge that registered the result
  always @(negedge clk) if (rstN && !done) begin
    if (rspValid) begin
      if (expQ.size() == 0) check("R7", 1, 0);
      else begin
        logic [2*W+4-1:0] e;
        e = expQ.pop_front();
        check(reqName(e[2*W+3:2*W]), rspResult, e[2*W-1:W]);
        check("R6", rspOrig, e[W-1:0]);
      end
    end
  end

  initial begin
    logic [W-1:0] corners[4];
    logic [W-1:0] heldR, heldO;
    corners[0] = '0; corners[1] = '1;
    corners[2] = {1'b1, {(W-1){1'b0}}}; corners[3] = {1'b0, {(W-1){1'b1}}};
    repeat (3) @(negedge clk);
    check("R8", {31'b0, rspValid}, 0);
    check("R8", rspResult, 0);
    check("R8", rspOrig, 0);
    rstN = 1'b1;
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          drive(4'(op), corners[i], corners[j]);
    idle();
    // R1: carry dropped
    drive(4'd0, 32'hFFFF_FFFF, 32'h2);
    // R3 vs R4: differing sign interpretation
    drive(4'd4, 32'h8000_0001, 32'h1);
    drive(4'd6, 32'h8000_0001, 32'h1);
    drive(4'd5, 32'hFFFF_FFFE, 32'h3);
    drive(4'd7, 32'hFFFF_FFFE, 32'h3);
    idle();
    for (int k = 0; k < 600; k++) begin
      if (k % 5 == 0) idle();
      else drive(4'($urandom), $urandom, $urandom);
    end
    idle();
    @(negedge clk);
    heldR = rspResult; heldO = rspOrig;
    check("R7", {31'b0, rspValid}, 0);
    repeat (3) idle();
    check("R7", rspResult, heldR);
    check("R7", rspOrig, heldO);
    @(negedge clk);
    check("R7", expQ.size(), 0);
    // R8: reset clears mid-run
    drive(4'd2, 32'h1234_5678, 32'h0F0F_0000);
    void'(expQ.pop_back());
    #1 rstN = 1'b0;
    #1;
    check("R8", rspResult, 0);
    check("R8", {31'b0, rspValid}, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule